// File: doc/BRIEF.md
# Windowed Heartbeat Supervisor

This block is an external supervisor for a processor. The guarded processor drives a heartbeat line as a level that it must toggle. Each transition of that line, rising or falling, counts as one beat. After power-up, and again after every reset the supervisor issues, it ignores the line for a long startup grace interval so that the processor can finish booting. The startup grace ends after 3 s. After that, beats must arrive at a nominal spacing of 500 ms, with 75 ms of tolerance either side. A beat that arrives too soon is a fault. So is a beat that fails to arrive by the end of the window. On a fault the supervisor drives a reset pulse of fixed length. It then records the cause in a sticky two-bit code and goes back to the grace interval.

All time limits are given in milliseconds and converted to clock ticks using a clock-frequency parameter, so a bench can shrink them. The heartbeat is asynchronous. It passes through a two-flop synchronizer, followed by an edge detector.

The controller has four states:

- GRACE: boot allowance.
- ARM: waiting for the first beat, which only starts interval timing.
- WATCH: window checking.
- PULSE: reset output driven.

The transitions are:

- GRACE→ARM when the grace count expires.
- ARM→WATCH on the first beat.
- ARM→PULSE when no beat arrives within the late limit.
- WATCH→WATCH on an in-window beat.
- WATCH→PULSE on an early beat or a missing beat.
- PULSE→GRACE when the pulse count expires.

Top module: `hb_window_supervisor`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it rises, `cpu_rst` is 0 and `fault_code` is 2'b00.
- R2: For GRACE_MS worth of ticks after power-on reset, heartbeat transitions have no effect and `cpu_rst` stays 0.
- R3: Rising and falling transitions of `hb_in` count equally as beats.
- R4: The first beat after the grace interval only starts interval timing and is never judged early. If no beat arrives within the late limit (NOMINAL_MS+TOL_MS ticks) after grace ends, a missing fault is raised.
- R5: A beat whose spacing from the previous accepted beat is between the early limit (NOMINAL_MS−TOL_MS ticks) and the late limit, both limits inclusive, is accepted and causes no reset.
- R6: A beat whose spacing is below the early limit raises an early fault, and `fault_code` becomes 2'b01.
- R7: When the late limit elapses with no beat, a missing fault is raised, and `fault_code` becomes 2'b10.
- R8: Every fault drives `cpu_rst` high for exactly RST_TICKS consecutive cycles.
- R9: `fault_code` keeps the cause of the latest fault (2'b00 none, 2'b01 early, 2'b10 missing) and is cleared only by `por_n`.
- R10: When the reset pulse ends, the grace interval starts again, and heartbeat transitions are ignored during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock at CLK_HZ |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| hb_in | input | 1 | Heartbeat level from the guarded processor, asynchronous |
| cpu_rst | output | 1 | Active-high reset pulse to the processor |
| fault_code | output | 2 | Sticky cause of the last fault: 00 none, 01 early, 10 missing |

## Verification
The assertions assume that `hb_in` changes at most once per window of interest. They also assume that a transition held for at least a few clocks reaches the edge detector as a single one-cycle pulse. The bench satisfies this by changing `hb_in` only at falling clock edges, never more than once per cycle, and with every pair of transitions many cycles apart. The bench also assumes that `por_n` is held low across several clock edges. Every bench scenario releases it only at a falling edge, so the asynchronous reset ends cleanly before the next rising edge.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    typedef enum logic [1:0] {
        ST_GRACE = 2'd0,
        ST_ARM   = 2'd1,
        ST_WATCH = 2'd2,
        ST_PULSE = 2'd3
    } hbw_state_e;

    localparam logic [1:0] CAUSE_NONE  = 2'b00;
    localparam logic [1:0] CAUSE_EARLY = 2'b01;
    localparam logic [1:0] CAUSE_MISS  = 2'b10;

endpackage

// File: rtl/hbw_sync_edge.sv
module hbw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    // STAGES flops for metastability, plus one more to hold the previous level
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign edge_o = pipe[STAGES] ^ pipe[STAGES-1];

endmodule

// File: rtl/hbw_interval_ctr.sv
module hbw_interval_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    // cnt holds the number of cycles since the last restart, counting the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= W'(1);
        else if (restart) cnt <= W'(1);
        else              cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/hb_window_supervisor.sv
module hb_window_supervisor
    import hbw_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int GRACE_MS   = 3000,
    parameter int NOMINAL_MS = 500,
    parameter int TOL_MS     = 75,
    parameter int RST_TICKS  = 16,
    parameter int SYNC_FLOPS = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       hb_in,
    output logic       cpu_rst,
    output logic [1:0] fault_code
);
    localparam int TICKS_PER_MS = CLK_HZ / 1000;
    localparam int GRACE_T      = TICKS_PER_MS * GRACE_MS;
    localparam int EARLY_T      = TICKS_PER_MS * (NOMINAL_MS - TOL_MS);
    localparam int LATE_T       = TICKS_PER_MS * (NOMINAL_MS + TOL_MS);
    localparam int MAX_A        = (GRACE_T > LATE_T) ? GRACE_T : LATE_T;
    localparam int MAX_T        = (MAX_A > RST_TICKS) ? MAX_A : RST_TICKS;
    localparam int CW           = $clog2(MAX_T + 1) + 1;

    localparam logic [CW-1:0] GRACE_C = CW'(GRACE_T);
    localparam logic [CW-1:0] EARLY_C = CW'(EARLY_T);
    localparam logic [CW-1:0] LATE_C  = CW'(LATE_T);
    localparam logic [CW-1:0] PULSE_C = CW'(RST_TICKS);

    hbw_state_e    state, state_n;
    logic          hb_edge;
    logic          restart;
    logic [CW-1:0] tick_cnt;
    logic [1:0]    cause_n;
    logic          rst_q;
    logic [1:0]    code_q;

    hbw_sync_edge #(.STAGES(SYNC_FLOPS)) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .async_in(hb_in),
        .edge_o  (hb_edge)
    );

    hbw_interval_ctr #(.W(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (por_n),
        .restart(restart),
        .cnt    (tick_cnt)
    );

    // next-state and transition decode
    always_comb begin
        state_n = state;
        restart = 1'b0;
        cause_n = CAUSE_NONE;
        unique case (state)
            ST_GRACE: begin
                if (tick_cnt == GRACE_C) begin
                    state_n = ST_ARM;
                    restart = 1'b1;
                end
            end
            ST_ARM: begin
                if (hb_edge) begin
                    state_n = ST_WATCH;
                    restart = 1'b1;
                end else if (tick_cnt == LATE_C) begin
                    state_n = ST_PULSE;
                    restart = 1'b1;
                    cause_n = CAUSE_MISS;
                end
            end
            ST_WATCH: begin
                if (hb_edge) begin
                    restart = 1'b1;
                    if (tick_cnt < EARLY_C) begin
                        state_n = ST_PULSE;
                        cause_n = CAUSE_EARLY;
                    end
                end else if (tick_cnt == LATE_C) begin
                    state_n = ST_PULSE;
                    restart = 1'b1;
                    cause_n = CAUSE_MISS;
                end
            end
            ST_PULSE: begin
                if (tick_cnt == PULSE_C) begin
                    state_n = ST_GRACE;
                    restart = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_GRACE;
        else        state <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_q  <= 1'b0;
            code_q <= CAUSE_NONE;
        end else begin
            rst_q <= (state_n == ST_PULSE);
            if (cause_n != CAUSE_NONE) code_q <= cause_n;
        end
    end

    assign cpu_rst    = rst_q;
    assign fault_code = code_q;

endmodule

// File: rtl/hbw_checker.sv
module hbw_checker
    import hbw_pkg::*;
#(
    parameter int CW      = 8,
    parameter int EARLY_T = 10,
    parameter int LATE_T  = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_rst,
    input logic [1:0]    fault_code,
    input hbw_state_e    state,
    input logic [CW-1:0] cnt,
    input logic          hb_edge
);
    localparam logic [CW-1:0] EARLY_C = CW'(EARLY_T);
    localparam logic [CW-1:0] LATE_C  = CW'(LATE_T);

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst) |-> fault_code != CAUSE_NONE); // R8

    AST_EARLY_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_rst) && $past(hb_edge)) |-> fault_code == CAUSE_EARLY); // R6

    AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code != CAUSE_NONE |=> fault_code != CAUSE_NONE); // R9

    AST_WATCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WATCH |-> cnt <= LATE_C); // R7

    AST_IN_WINDOW_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_edge && state == ST_WATCH && cnt >= EARLY_C) |=> !cpu_rst); // R5

    AST_PULSE_TO_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst) |-> state == ST_GRACE); // R10

endmodule

bind hb_window_supervisor hbw_checker #(
    .CW     (CW),
    .EARLY_T(EARLY_T),
    .LATE_T (LATE_T)
) u_chk (
    .clk       (clk),
    .rst_n     (por_n),
    .cpu_rst   (cpu_rst),
    .fault_code(fault_code),
    .state     (state),
    .cnt       (tick_cnt),
    .hb_edge   (hb_edge)
);

// File: tb/sim_hb_window_supervisor.sv
`timescale 1ns/1ps
module sim_hb_window_supervisor;
    // CLK_HZ is scaled down to 2 ticks per ms so that the time limits stay short:
    // grace 6000, early 850, late 1150, pulse 8 ticks
    localparam int EARLY  = 850;
    localparam int LATE   = 1150;
    localparam int PULSE  = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       hb_in = 1'b0;
    logic       cpu_rst;
    logic [1:0] fault_code;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int hi_cycles = 0;
    logic prev_rst = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_window_supervisor #(
        .CLK_HZ   (2000),
        .RST_TICKS(PULSE)
    ) u0 (
        .clk       (clk),
        .por_n     (por_n),
        .hb_in     (hb_in),
        .cpu_rst   (cpu_rst),
        .fault_code(fault_code)
    );

    always @(negedge clk) begin
        if (cpu_rst) hi_cycles++;
        if (cpu_rst && !prev_rst) rises++;
        prev_rst = cpu_rst;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rises = 0;
        hi_cycles = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_after(input int n);
        repeat (n) @(negedge clk);
        hb_in = ~hb_in;
    endtask

    task automatic t_power_on();
        por_n = 1'b0;
        wait_cyc(4);
        check("R1 rst in reset", int'(cpu_rst), 0);
        check("R1 code in reset", int'(fault_code), 0);
        por_n = 1'b1;
        wait_cyc(1);
        check("R1 rst after release", int'(cpu_rst), 0);
        clear_mon();
    endtask

    task automatic t_grace_ignore();
        for (int i = 0; i < 150; i++) toggle_after(37);
        wait_cyc(6100 - 5551);
        check("R2 no reset during grace", rises, 0);
        check("R2 code after grace", int'(fault_code), 0);
    endtask

    task automatic t_window_ok();
        clear_mon();
        hb_in = ~hb_in;          // first beat, spacing from grace end is short
        wait_cyc(20);
        check("R4 first beat not judged", rises, 0);
        toggle_after(1000 - 20); // R3: falling/rising alternate
        toggle_after(EARLY);     // lower bound inclusive
        toggle_after(LATE);      // upper bound inclusive
        toggle_after(1000);
        wait_cyc(20);
        check("R5 in-window beats", rises, 0);
        check("R5 code unchanged", int'(fault_code), 0);
    endtask

    task automatic t_early();
        clear_mon();
        toggle_after(EARLY - 1 - 20);
        wait_cyc(30);
        check("R6 early reset", rises, 1);
        check("R8 early pulse width", hi_cycles, PULSE);
        check("R6 early code", int'(fault_code), 1);
    endtask

    task automatic t_regrace_then_missing();
        clear_mon();
        for (int i = 0; i < 125; i++) toggle_after(40);
        wait_cyc(1100);
        check("R10 grace after pulse", rises, 0);
        check("R9 code held", int'(fault_code), 1);
        hb_in = ~hb_in;
        toggle_after(1000);
        wait_cyc(20);
        check("R5 beat after regrace", rises, 0);
        clear_mon();
        wait_cyc(LATE + 50 - 20);
        check("R7 missing reset", rises, 1);
        check("R8 missing pulse width", hi_cycles, PULSE);
        check("R7 missing code", int'(fault_code), 2);
    endtask

    task automatic t_arm_timeout();
        clear_mon();
        wait_cyc(7300);
        check("R4 no first beat faults", rises, 1);
        check("R9 code after arm timeout", int'(fault_code), 2);
    endtask

    task automatic t_por_clears();
        @(negedge clk);
        por_n = 1'b0;
        wait_cyc(3);
        check("R9 code cleared by por", int'(fault_code), 0);
        check("R1 rst cleared by por", int'(cpu_rst), 0);
        por_n = 1'b1;
        wait_cyc(2);
    endtask

    initial begin
        t_power_on();
        t_grace_ignore();
        t_window_ok();
        t_early();
        t_regrace_then_missing();
        t_arm_timeout();
        t_por_clears();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule